// File: doc/BRIEF.md
# Handshake Memory Bus Fabric

This block links one bus master to up to twelve memory-mapped slaves. The master places a 16-bit address, its write data and a write flag on its side and raises a request. The fabric takes the transfer in on a clock edge. It decodes the top address byte into a single slave select and forwards the request to that slave alone. Address, write data and write flag go out on shared lines that every slave sees. The read and write data paths are separate, so no bus is ever tristated.

Each slave answers with a four-phase handshake. The slave acknowledges once its response data is valid and may stall for as many cycles as it needs. The fabric picks that slave's acknowledge and read data through a select-driven multiplexer, registers them and returns them to the master. The master then drops its request. The slave drops its acknowledge, and only then does the fabric clear the master's acknowledge.

A request whose top byte matches no slave is answered internally with zero data, so the master never hangs. All outputs come from registers, so no combinational path runs from the master's request to any response.

Top module: `bus_fabric`

## Requirements
- R1: While reset is held, `m_ack`, every bit of `s_req` and `m_rdata` are zero.
- R2: A request with top address byte k, where k < 12, raises only bit k of `s_req`, on the first clock edge after `m_req` is sampled high.
- R3: While a slave request is raised, `s_addr`, `s_wdata` and `s_we` equal the values the master drove when its request was accepted.
- R4: `m_ack` rises on the clock edge after the selected slave's acknowledge is first seen. From raised request to visible acknowledge, the master waits 3 cycles plus the slave's stall cycles.
- R5: `m_rdata` carries the selected slave's read data, captured when that slave acknowledges. The read data of every other slave is ignored.
- R6: Once raised, `m_ack` and the slave request stay high for as long as `m_req` stays high.
- R7: After `m_req` falls, the slave request falls on the next edge. `m_ack` falls only on the edge after the selected slave's acknowledge falls, which makes 3 cycles plus the slave's release delay.
- R8: A top address byte of 12 or above raises no `s_req` bit. It is acknowledged 2 cycles after the request with `m_rdata` equal to zero, and `m_ack` clears 2 cycles after the request falls.
- R9: Changing `m_addr` or `m_wdata` during a transfer changes neither the selected slave nor the shared slave address or write data until the transfer is over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_req | input | 1 | Master transfer request |
| m_we | input | 1 | Master write flag (1 = write) |
| m_addr | input | 16 | Master address; top byte selects the slave |
| m_wdata | input | 16 | Master write data |
| m_rdata | output | 16 | Read data returned to the master |
| m_ack | output | 1 | Acknowledge to the master |
| s_req | output | 12 | Per-slave request, one-hot or zero |
| s_we | output | 1 | Shared write flag to all slaves |
| s_addr | output | 16 | Shared address to all slaves |
| s_wdata | output | 16 | Shared write data to all slaves |
| s_rdata | input | 192 | Slave read data, slave i at bits [16i+15:16i] |
| s_ack | input | 12 | Per-slave acknowledge |

## Verification
A wrong handshake state shows up within a transfer: the master would see an acknowledge too early or too late against the exact latency and release counts, or never see one. A stale or corrupted select shows up in the same transfer, either as a second bit on `s_req` or as read data from the wrong slave. A wrong captured address shows up as a write landing in the wrong word, which a later read back reveals. Changing the master address in mid-transfer and stretching the request are applied on purpose, to expose any select or acknowledge that is not held.

// File: rtl/busfab_pkg.sv
package busfab_pkg;

    // Handshake phase of the single outstanding transfer.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,  // waiting for a master request
        ST_ISSUE = 2'd1,  // request forwarded, waiting for slave acknowledge
        ST_HOLD  = 2'd2,  // master acknowledged, waiting for request release
        ST_DRAIN = 2'd3   // request released, waiting for slave acknowledge release
    } hs_state_e;

endpackage

// File: rtl/busfab_decode.sv
module busfab_decode #(
    parameter int N_SLV = 12,
    parameter int SEL_W = 8
) (
    input  logic [SEL_W-1:0] bank_i,
    output logic [N_SLV-1:0] onehot_o,
    output logic             hit_o
);

    // One comparator per slave: slave i owns bank value i.
    for (genvar i = 0; i < N_SLV; i++) begin : g_cmp
        assign onehot_o[i] = (bank_i == SEL_W'(i));
    end

    assign hit_o = |onehot_o;

endmodule

// File: rtl/busfab_retmux.sv
module busfab_retmux #(
    parameter int N_SLV = 12,
    parameter int DW    = 16
) (
    input  logic [N_SLV-1:0]    sel_i,
    input  logic [N_SLV*DW-1:0] rdata_i,
    input  logic [N_SLV-1:0]    ack_i,
    output logic [DW-1:0]       rdata_o,
    output logic                ack_o
);

    logic [DW-1:0]    masked [N_SLV];
    logic [N_SLV-1:0] ack_m;

    // Gate each slave's response with its select, then OR-reduce.
    for (genvar i = 0; i < N_SLV; i++) begin : g_mask
        assign masked[i] = sel_i[i] ? rdata_i[i*DW +: DW] : '0;
        assign ack_m[i]  = sel_i[i] & ack_i[i];
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < N_SLV; i++) begin
            rdata_o = rdata_o | masked[i];
        end
    end

    assign ack_o = |ack_m;

endmodule

// File: rtl/busfab_ctrl.sv
module busfab_ctrl
    import busfab_pkg::*;
#(
    parameter int N_SLV = 12,
    parameter int AW    = 16,
    parameter int DW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             m_req,
    input  logic             m_we,
    input  logic [AW-1:0]    m_addr,
    input  logic [DW-1:0]    m_wdata,
    input  logic [N_SLV-1:0] dec_onehot,
    input  logic             dec_hit,
    input  logic             mux_ack,
    input  logic [DW-1:0]    mux_rdata,
    output logic             m_ack,
    output logic [DW-1:0]    m_rdata,
    output logic [N_SLV-1:0] s_req,
    output logic             s_we,
    output logic [AW-1:0]    s_addr,
    output logic [DW-1:0]    s_wdata,
    output logic [N_SLV-1:0] sel
);

    typedef struct packed {
        hs_state_e        st;
        logic [N_SLV-1:0] sel;
        logic             hit;
        logic [N_SLV-1:0] sreq;
        logic             we;
        logic [AW-1:0]    addr;
        logic [DW-1:0]    wdata;
        logic             ack;
        logic [DW-1:0]    rdata;
    } ctrl_t;

    ctrl_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (m_req) begin
                    r_d.st    = ST_ISSUE;
                    r_d.sel   = dec_onehot;
                    r_d.hit   = dec_hit;
                    r_d.sreq  = dec_onehot;
                    r_d.we    = m_we;
                    r_d.addr  = m_addr;
                    r_d.wdata = m_wdata;
                end
            end
            ST_ISSUE: begin
                if (!r_q.hit) begin
                    // Default responder: unmapped bank answers with zero data.
                    r_d.st    = ST_HOLD;
                    r_d.ack   = 1'b1;
                    r_d.rdata = '0;
                end else if (mux_ack) begin
                    r_d.st    = ST_HOLD;
                    r_d.ack   = 1'b1;
                    r_d.rdata = mux_rdata;
                end
            end
            ST_HOLD: begin
                if (!m_req) begin
                    r_d.st   = ST_DRAIN;
                    r_d.sreq = '0;
                end
            end
            ST_DRAIN: begin
                if (!r_q.hit || !mux_ack) begin
                    r_d.st  = ST_IDLE;
                    r_d.ack = 1'b0;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign m_ack   = r_q.ack;
    assign m_rdata = r_q.rdata;
    assign s_req   = r_q.sreq;
    assign s_we    = r_q.we;
    assign s_addr  = r_q.addr;
    assign s_wdata = r_q.wdata;
    assign sel     = r_q.sel;

    // R2: at most one slave is ever requested
    a_r2_one_slave: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s_req));

    // R3 / R9: shared address and data hold while a transfer is open
    a_r9_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_IDLE) |=> (r_q.st == ST_IDLE || ($stable(s_addr) && $stable(s_wdata) && $stable(sel))));

    // R4: master acknowledge follows a slave acknowledge or the default responder
    a_r4_ack_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (!m_ack ##1 m_ack) |-> (!r_q.hit || $past(mux_ack)));

    // R6: acknowledge held while master keeps its request
    a_r6_ack_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (m_ack && m_req) |=> m_ack);

    // R7: acknowledge clears only after the slave released its acknowledge
    a_r7_release_order: assert property (@(posedge clk) disable iff (!rst_n)
        (m_ack ##1 !m_ack) |-> (!r_q.hit || !$past(mux_ack)));

    // R8: an unmapped bank never requests a slave
    a_r8_no_unmapped_req: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_IDLE && !r_q.hit) |-> (s_req == '0));

endmodule

// File: rtl/bus_fabric.sv
module bus_fabric #(
    parameter int N_SLV = 12,
    parameter int AW    = 16,
    parameter int DW    = 16,
    parameter int SEL_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               m_req,
    input  logic               m_we,
    input  logic [AW-1:0]      m_addr,
    input  logic [DW-1:0]      m_wdata,
    output logic [DW-1:0]      m_rdata,
    output logic               m_ack,
    output logic [N_SLV-1:0]   s_req,
    output logic               s_we,
    output logic [AW-1:0]      s_addr,
    output logic [DW-1:0]      s_wdata,
    input  logic [N_SLV*DW-1:0] s_rdata,
    input  logic [N_SLV-1:0]   s_ack
);

    logic [N_SLV-1:0] dec_onehot;
    logic             dec_hit;
    logic [N_SLV-1:0] sel;
    logic             mux_ack;
    logic [DW-1:0]    mux_rdata;

    busfab_decode #(.N_SLV(N_SLV), .SEL_W(SEL_W)) u_dec (
        .bank_i   (m_addr[AW-1 -: SEL_W]),
        .onehot_o (dec_onehot),
        .hit_o    (dec_hit)
    );

    busfab_retmux #(.N_SLV(N_SLV), .DW(DW)) u_mux (
        .sel_i   (sel),
        .rdata_i (s_rdata),
        .ack_i   (s_ack),
        .rdata_o (mux_rdata),
        .ack_o   (mux_ack)
    );

    busfab_ctrl #(.N_SLV(N_SLV), .AW(AW), .DW(DW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .m_req      (m_req),
        .m_we       (m_we),
        .m_addr     (m_addr),
        .m_wdata    (m_wdata),
        .dec_onehot (dec_onehot),
        .dec_hit    (dec_hit),
        .mux_ack    (mux_ack),
        .mux_rdata  (mux_rdata),
        .m_ack      (m_ack),
        .m_rdata    (m_rdata),
        .s_req      (s_req),
        .s_we       (s_we),
        .s_addr     (s_addr),
        .s_wdata    (s_wdata),
        .sel        (sel)
    );

endmodule

// File: tb/sim_bus_fabric.sv
module sim_bus_fabric;

    localparam int N  = 12;
    localparam int DW = 16;
    localparam int AW = 16;
    localparam int NV = 11;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            m_req = 1'b0;
    logic            m_we = 1'b0;
    logic [AW-1:0]   m_addr = '0;
    logic [DW-1:0]   m_wdata = '0;
    logic [DW-1:0]   m_rdata;
    logic            m_ack;
    logic [N-1:0]    s_req;
    logic            s_we;
    logic [AW-1:0]   s_addr;
    logic [DW-1:0]   s_wdata;
    logic [N*DW-1:0] s_rdata;
    logic [N-1:0]    s_ack;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bus_fabric u0 (
        .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
        .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ack(m_ack), .s_req(s_req),
        .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata), .s_rdata(s_rdata),
        .s_ack(s_ack)
    );

    // Register-file slave models: slave k stalls k%4 cycles and,
    // for slave 11 only, holds its acknowledge 3 extra cycles on release.
    function automatic int lat_of(int k);
        return k % 4;
    endfunction
    function automatic int rel_of(int k);
        return (k == 11) ? 3 : 0;
    endfunction

    for (genvar i = 0; i < N; i++) begin : g_slv
        logic [DW-1:0] mem [4];
        logic          ack_r;
        int            cnt;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int w = 0; w < 4; w++) mem[w] <= 16'hA000 + 16'(i * 16 + w);
                ack_r <= 1'b0;
                cnt   <= 0;
            end else if (s_req[i] && !ack_r) begin
                if (cnt == lat_of(i)) begin
                    ack_r <= 1'b1;
                    cnt   <= 0;
                    if (s_we) mem[s_addr[1:0]] <= s_wdata;
                end else begin
                    cnt <= cnt + 1;
                end
            end else if (!s_req[i] && ack_r) begin
                if (cnt == rel_of(i)) begin
                    ack_r <= 1'b0;
                    cnt   <= 0;
                end else begin
                    cnt <= cnt + 1;
                end
            end
        end
        assign s_rdata[i*DW +: DW] = mem[s_addr[1:0]];
        assign s_ack[i] = ack_r;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // {we, addr, wdata, expected read data}
    localparam logic [48:0] VEC [NV] = '{
        {1'b1, 16'h0001, 16'h1111, 16'h0000},
        {1'b1, 16'h0B03, 16'hBBBB, 16'h0000},
        {1'b1, 16'h0502, 16'h5555, 16'h0000},
        {1'b0, 16'h0001, 16'h0000, 16'h1111},
        {1'b0, 16'h0B03, 16'h0000, 16'hBBBB},
        {1'b0, 16'h0502, 16'h0000, 16'h5555},
        {1'b0, 16'h0302, 16'h0000, 16'hA032},
        {1'b0, 16'h0700, 16'h0000, 16'hA070},
        {1'b0, 16'h0C00, 16'h0000, 16'h0000},
        {1'b0, 16'hFF01, 16'h0000, 16'h0000},
        {1'b1, 16'h2000, 16'h1234, 16'h0000}
    };

    task automatic xfer(input logic we, input logic [AW-1:0] addr, input logic [DW-1:0] wd,
                        output logic [DW-1:0] rd, output int lat, output int rel,
                        output logic [N-1:0] seen, output bit shared_ok);
        @(negedge clk);
        m_we = we; m_addr = addr; m_wdata = wd; m_req = 1'b1;
        lat = 0; seen = '0; shared_ok = 1'b1;
        do begin
            @(negedge clk);
            lat++;
            seen |= s_req;
            if (s_req != '0 && (s_addr != addr || s_wdata != wd || s_we != we)) shared_ok = 1'b0;
        end while (!m_ack && lat < 60);
        rd = m_rdata;
        m_req = 1'b0;
        rel = 0;
        do begin
            @(negedge clk);
            rel++;
        end while (m_ack && rel < 60);
    endtask

    initial begin
        logic [DW-1:0] rd;
        logic [N-1:0]  seen;
        int lat, rel, k;
        bit sok, ok;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(m_ack == 1'b0, "R1", "m_ack in reset", 32'(m_ack), 0);
        check(s_req == '0, "R1", "s_req in reset", 32'(s_req), 0);
        check(m_rdata == '0, "R1", "m_rdata in reset", 32'(m_rdata), 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            logic          we  = VEC[v][48];
            logic [AW-1:0] ad  = VEC[v][47:32];
            logic [DW-1:0] wd  = VEC[v][31:16];
            logic [DW-1:0] ex  = VEC[v][15:0];
            k = int'(ad[15:8]);
            xfer(we, ad, wd, rd, lat, rel, seen, sok);
            if (k < N) begin
                check(seen == N'(1) << k, "R2", "selected slave", 32'(seen), 32'(N'(1) << k));
                check(sok, "R3", "shared lines", 32'(sok), 1);
                check(lat == 3 + lat_of(k), "R4", "ack latency", 32'(lat), 32'(3 + lat_of(k)));
                check(rel == 3 + rel_of(k), "R7", "release cycles", 32'(rel), 32'(3 + rel_of(k)));
                if (!we) check(rd == ex, "R5", "read data", 32'(rd), 32'(ex));
            end else begin
                check(seen == '0, "R8", "no slave requested", 32'(seen), 0);
                check(lat == 2 && rel == 2, "R8", "default timing", 32'(lat * 256 + rel), 32'h202);
                check(rd == '0, "R8", "default read data", 32'(rd), 0);
            end
        end

        // R9: address and data change mid-transfer to slave 5 word 1
        @(negedge clk);
        m_we = 1'b0; m_addr = 16'h0501; m_wdata = 16'h0; m_req = 1'b1;
        @(negedge clk);
        m_addr = 16'h0002; m_wdata = 16'hDEAD; m_we = 1'b1;
        ok = 1'b1; lat = 1;
        while (!m_ack && lat < 60) begin
            if (s_req != 12'h020 || s_addr != 16'h0501 || s_we != 1'b0) ok = 1'b0;
            @(negedge clk);
            lat++;
        end
        check(ok, "R9", "select and address held", 32'(s_addr), 32'h0501);
        check(m_rdata == 16'hA051, "R9", "data from original slave", 32'(m_rdata), 32'hA051);

        // R6: keep request high after acknowledge
        ok = 1'b1;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            if (!m_ack || s_req != 12'h020) ok = 1'b0;
        end
        check(ok, "R6", "ack and s_req held", 32'(m_ack), 1);
        m_req = 1'b0;
        rel = 0;
        do begin @(negedge clk); rel++; end while (m_ack && rel < 60);
        check(s_req == '0, "R7", "s_req cleared after release", 32'(s_req), 0);

        // R5: other slaves' data ignored; slave 0 word 1 still holds its write
        xfer(1'b0, 16'h0001, 16'h0, rd, lat, rel, seen, sok);
        check(rd == 16'h1111, "R5", "slave0 readback", 32'(rd), 32'h1111);
        // Unmapped write at 0x2000 left slave 0 word 0 untouched
        xfer(1'b0, 16'h0000, 16'h0, rd, lat, rel, seen, sok);
        check(rd == 16'hA000, "R8", "unmapped write ignored", 32'(rd), 32'hA000);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule